// File: doc/BRIEF.md
# Disk Sector Read Stream Sequencer

This block paces the read stream of an emulated rotating disk, one sector at a time. Each sector opens with a marker pulse. A run of zero-valued bit cells follows, then a sync word, then a fixed number of data words of 20 bit cells each. After the last data word of the last sector, the sector number returns to zero and the next rotation begins. A bit cell is a fixed number of clock cycles, and every word slot is a whole number of cells.

The block does not shift bits out itself. At the first cycle of every word slot it raises a one-cycle start trigger and presents the word to send on `word_load`. A separate bit-cell serializer copies that word on the trigger. The serializer never free-runs, so it can never drift away from the sector timing.

Data words come from a synchronous RAM. The RAM returns data one cycle after `ram_rd_en`. Each data word is read a fixed number of cycles ahead of its slot and kept in a holding register. That register changes only after the previous word has been handed over. The preamble and sync cells make no RAM access.

Top module: `dsr_read_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, the outputs show the start of sector 0: `sector_idx`=0, `sector_mark`=1, `preamble_active`=1, `cell_tick`=1, `word_start`=0, `ram_rd_en`=0. A reset in the middle of a sector restarts this sequence from the beginning.
- R2: `sector_mark` is high for exactly MARK_CLKS cycles, starting in the first cycle of every sector, and is low for the rest of the sector.
- R3: Every sector begins with PREAMBLE_CELLS×CELL_CLKS cycles with `preamble_active`=1. In these cycles there is no start trigger and no RAM read.
- R4: In the first cycle after the preamble, `word_start`=1, `word_is_sync`=1 and `word_load` equals SYNC_WORD. `word_is_sync` stays high for one word slot (WORD_CELLS×CELL_CLKS cycles).
- R5: After the sync slot come WORDS_PER_SECTOR data slots, each WORD_CELLS×CELL_CLKS cycles long. Each slot begins with a `word_start` pulse exactly one cycle wide, and there are no other pulses.
- R6: `ram_rd_en` is high for one cycle exactly FETCH_LEAD cycles before each data-word trigger, and at no other time. In that cycle `ram_addr` = sector × WORDS_PER_SECTOR + word, with word counted from 0.
- R7: At each data-word trigger, `word_load` equals the RAM data read for that word's address. The holding register does not change between the arrival of that data and the trigger.
- R8: The next sector starts in the cycle after the last data slot ends. `sector_idx` counts up by one per sector and returns to 0 after NUM_SECTORS−1. A sector lasts (PREAMBLE_CELLS + WORD_CELLS×(WORDS_PER_SECTOR+1))×CELL_CLKS cycles.
- R9: `cell_tick` is high in the first cycle of every bit cell, which is once every CELL_CLKS cycles, counted from the start of the sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ram_rd_data | input | DATA_W | RAM read data, valid one cycle after `ram_rd_en` |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_addr | output | clog2(NUM_SECTORS×WORDS_PER_SECTOR) | RAM word address |
| sector_mark | output | 1 | Sector marker pulse |
| cell_tick | output | 1 | First cycle of a bit cell |
| preamble_active | output | 1 | Zero-cell run in progress |
| word_start | output | 1 | One-cycle trigger to the serializer |
| word_is_sync | output | 1 | Current slot is the sync word |
| word_load | output | DATA_W | Word for the serializer to copy on `word_start` |
| sector_idx | output | clog2(NUM_SECTORS) | Current sector number |

## Verification
The bench models the RAM so that each address returns a distinct value. Because of this, a word taken from a wrong address, or from a read one slot too early or too late, shows up as a mismatch on `word_load`. The whole output set is compared on every cycle against a timeline worked out from the sector length, over two full rotations. This separates the marker, preamble, sync and data phases, and it exposes an off-by-one in the slot length, the read lead or the sector wrap. A table of probe cycles pins down the exact edges: the end of the marker, the sync trigger, the first and last reads, and the rotation wrap. A reset in the middle of a data slot checks that the sequence restarts cleanly.

// File: rtl/dsr_pkg.sv
// Package: types shared by the read stream sequencer modules.
package dsr_pkg;

    // Which part of the sector the sequencer is in.
    typedef enum logic [1:0] {
        PH_PRE  = 2'd0,
        PH_SYNC = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

endpackage

// File: rtl/dsr_cell_timer.sv
// Counts the clock cycles inside one bit cell.
// Assumes CELL_CLKS >= 2. It restarts at zero after reset, so cells line
// up with the start of the sector.
module dsr_cell_timer #(
    parameter int CELL_CLKS = 70,
    localparam int CLK_W    = $clog2(CELL_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CLK_W-1:0] clk_pos,
    output logic             cell_last
);

    logic [CLK_W-1:0] cnt_q;

    assign cell_last = (cnt_q == CLK_W'(CELL_CLKS - 1));
    assign clk_pos   = cnt_q;

    // Free-running cycle counter that wraps once per bit cell.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (cell_last) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/dsr_sector_ctrl.sv
// Sector-level controller. It walks through preamble, sync slot and data
// slots, and counts words and sectors. It raises the serializer trigger,
// the marker pulse and the RAM fetch request.
// Assumes 3 <= FETCH_LEAD <= CELL_CLKS, and that MARK_CLKS is shorter than
// the preamble minus the fetch lead.
module dsr_sector_ctrl
    import dsr_pkg::*;
#(
    parameter int CELL_CLKS        = 70,
    parameter int WORD_CELLS       = 20,
    parameter int WORDS_PER_SECTOR = 321,
    parameter int PREAMBLE_CELLS   = 250,
    parameter int NUM_SECTORS      = 8,
    parameter int MARK_CLKS        = 10,
    parameter int FETCH_LEAD       = 4,
    localparam int CLK_W   = $clog2(CELL_CLKS),
    localparam int MAXC    = (PREAMBLE_CELLS > WORD_CELLS) ? PREAMBLE_CELLS : WORD_CELLS,
    localparam int CELL_W  = $clog2(MAXC + 1),
    localparam int WORD_W  = $clog2(WORDS_PER_SECTOR),
    localparam int SEC_W   = $clog2(NUM_SECTORS),
    localparam int MARK_W  = $clog2(MARK_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CLK_W-1:0]  clk_pos,
    input  logic              cell_last,
    output phase_e            phase,
    output logic [SEC_W-1:0]  sector,
    output logic [WORD_W-1:0] fetch_word,
    output logic              fetch_req,
    output logic              word_start,
    output logic              mark
);

    phase_e            phase_q;
    logic [CELL_W-1:0] cell_q;
    logic [WORD_W-1:0] word_q;
    logic [SEC_W-1:0]  sector_q;
    logic [MARK_W-1:0] mark_q;
    logic [CELL_W-1:0] phase_last_cell;
    logic              phase_done;
    logic              slot_last_cell;
    logic              last_word;
    logic              sector_end;

    // Number of the last cell in the current phase.
    assign phase_last_cell = (phase_q == PH_PRE) ? CELL_W'(PREAMBLE_CELLS - 1)
                                                 : CELL_W'(WORD_CELLS - 1);
    assign phase_done      = cell_last && (cell_q == phase_last_cell);
    assign slot_last_cell  = (cell_q == CELL_W'(WORD_CELLS - 1));
    assign last_word       = (word_q == WORD_W'(WORDS_PER_SECTOR - 1));
    assign sector_end      = phase_done && (phase_q == PH_DATA) && last_word;

    // Phase, cell, word and sector counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_PRE;
            cell_q   <= '0;
            word_q   <= '0;
            sector_q <= '0;
        end else if (phase_done) begin
            cell_q <= '0;
            case (phase_q)
                PH_PRE:  phase_q <= PH_SYNC;
                PH_SYNC: begin
                    phase_q <= PH_DATA;
                    word_q  <= '0;
                end
                PH_DATA: begin
                    if (last_word) begin
                        phase_q  <= PH_PRE;
                        word_q   <= '0;
                        sector_q <= (sector_q == SEC_W'(NUM_SECTORS - 1)) ? '0
                                                                         : sector_q + 1'b1;
                    end else begin
                        word_q <= word_q + 1'b1;
                    end
                end
                default: phase_q <= PH_PRE;
            endcase
        end else if (cell_last) begin
            cell_q <= cell_q + 1'b1;
        end
    end

    // Marker pulse timer: loaded at reset and at every sector boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)               mark_q <= MARK_W'(MARK_CLKS);
        else if (sector_end)      mark_q <= MARK_W'(MARK_CLKS);
        else if (mark_q != '0)    mark_q <= mark_q - 1'b1;
    end

    // Trigger at the first cycle of every sync or data slot.
    assign word_start = (phase_q != PH_PRE) && (cell_q == '0) && (clk_pos == '0);

    // Fetch FETCH_LEAD cycles before the next data slot begins.
    assign fetch_req  = ((phase_q == PH_SYNC) || ((phase_q == PH_DATA) && !last_word))
                        && slot_last_cell
                        && (clk_pos == CLK_W'(CELL_CLKS - FETCH_LEAD));
    assign fetch_word = (phase_q == PH_SYNC) ? '0 : word_q + 1'b1;

    assign phase  = phase_q;
    assign sector = sector_q;
    assign mark   = (mark_q != '0);

endmodule

// File: rtl/dsr_word_fetch.sv
// RAM fetch and holding register. It turns a fetch request into a read at
// sector*WORDS_PER_SECTOR + word. The data comes back one cycle later and
// is stored in the holding register, where it stays until the next fetch.
// Assumes a synchronous RAM with one cycle of read latency.
module dsr_word_fetch #(
    parameter int DATA_W           = 16,
    parameter int WORDS_PER_SECTOR = 321,
    parameter int NUM_SECTORS      = 8,
    localparam int WORD_W = $clog2(WORDS_PER_SECTOR),
    localparam int SEC_W  = $clog2(NUM_SECTORS),
    localparam int ADDR_W = $clog2(NUM_SECTORS * WORDS_PER_SECTOR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [SEC_W-1:0]  sector,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] ram_rd_data,
    output logic              ram_rd_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] hold_word
);

    logic              pend_q;
    logic [DATA_W-1:0] hold_q;

    assign ram_rd_en = fetch_req;
    assign ram_addr  = ADDR_W'(sector) * ADDR_W'(WORDS_PER_SECTOR) + ADDR_W'(word);
    assign hold_word = hold_q;

    // Remember that read data is due in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= fetch_req;
    end

    // Capture the returned word; it is held until the next read returns.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (pend_q) hold_q <= ram_rd_data;
    end

endmodule

// File: rtl/dsr_read_seq.sv
// Top of the disk sector read stream sequencer. It joins the cell timer,
// the sector controller and the word fetch unit, and selects the word the
// serializer copies on word_start: the sync pattern or the prefetched word.
module dsr_read_seq
    import dsr_pkg::*;
#(
    parameter int DATA_W           = 16,
    parameter int CELL_CLKS        = 70,
    parameter int WORD_CELLS       = 20,
    parameter int WORDS_PER_SECTOR = 321,
    parameter int PREAMBLE_CELLS   = 250,
    parameter int NUM_SECTORS      = 8,
    parameter int MARK_CLKS        = 10,
    parameter int FETCH_LEAD       = 4,
    parameter logic [DATA_W-1:0] SYNC_WORD = 16'h8001,
    localparam int CLK_W  = $clog2(CELL_CLKS),
    localparam int WORD_W = $clog2(WORDS_PER_SECTOR),
    localparam int SEC_W  = $clog2(NUM_SECTORS),
    localparam int ADDR_W = $clog2(NUM_SECTORS * WORDS_PER_SECTOR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ram_rd_data,
    output logic              ram_rd_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              sector_mark,
    output logic              cell_tick,
    output logic              preamble_active,
    output logic              word_start,
    output logic              word_is_sync,
    output logic [DATA_W-1:0] word_load,
    output logic [SEC_W-1:0]  sector_idx
);

    // Elaboration-time checks on the timing parameters.
    generate
        if (FETCH_LEAD < 3 || FETCH_LEAD > CELL_CLKS) begin : g_bad_lead
            $error("FETCH_LEAD must lie in 3..CELL_CLKS");
        end
        if (MARK_CLKS + FETCH_LEAD >= PREAMBLE_CELLS * CELL_CLKS) begin : g_bad_mark
            $error("marker pulse must end inside the preamble");
        end
        if (NUM_SECTORS < 2 || WORDS_PER_SECTOR < 2 || CELL_CLKS < 2) begin : g_bad_size
            $error("sector, word and cell counts must be at least 2");
        end
    endgenerate

    phase_e            phase;
    logic [CLK_W-1:0]  clk_pos;
    logic              cell_last;
    logic [WORD_W-1:0] fetch_word;
    logic              fetch_req;
    logic [DATA_W-1:0] hold_word;

    dsr_cell_timer #(
        .CELL_CLKS (CELL_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_pos   (clk_pos),
        .cell_last (cell_last)
    );

    dsr_sector_ctrl #(
        .CELL_CLKS        (CELL_CLKS),
        .WORD_CELLS       (WORD_CELLS),
        .WORDS_PER_SECTOR (WORDS_PER_SECTOR),
        .PREAMBLE_CELLS   (PREAMBLE_CELLS),
        .NUM_SECTORS      (NUM_SECTORS),
        .MARK_CLKS        (MARK_CLKS),
        .FETCH_LEAD       (FETCH_LEAD)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_pos    (clk_pos),
        .cell_last  (cell_last),
        .phase      (phase),
        .sector     (sector_idx),
        .fetch_word (fetch_word),
        .fetch_req  (fetch_req),
        .word_start (word_start),
        .mark       (sector_mark)
    );

    dsr_word_fetch #(
        .DATA_W           (DATA_W),
        .WORDS_PER_SECTOR (WORDS_PER_SECTOR),
        .NUM_SECTORS      (NUM_SECTORS)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .sector      (sector_idx),
        .word        (fetch_word),
        .ram_rd_data (ram_rd_data),
        .ram_rd_en   (ram_rd_en),
        .ram_addr    (ram_addr),
        .hold_word   (hold_word)
    );

    // Phase flags and the word presented to the serializer.
    assign cell_tick       = (clk_pos == '0);
    assign preamble_active = (phase == PH_PRE);
    assign word_is_sync    = (phase == PH_SYNC);
    assign word_load       = word_is_sync ? SYNC_WORD : hold_word;

endmodule

// File: rtl/dsr_read_seq_sva.sv
// Protocol checker for dsr_read_seq, attached to the top with bind.
module dsr_read_seq_sva #(
    parameter int DATA_W      = 16,
    parameter int NUM_SECTORS = 8,
    localparam int SEC_W      = $clog2(NUM_SECTORS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sector_mark,
    input logic              cell_tick,
    input logic              word_start,
    input logic              word_is_sync,
    input logic              ram_rd_en,
    input logic [SEC_W-1:0]  sector_idx,
    input logic [DATA_W-1:0] hold_word
);

    // R5: the serializer trigger lasts exactly one cycle.
    assert_trigger_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |=> !word_start);

    // R6: each RAM read strobe lasts exactly one cycle.
    assert_read_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> !ram_rd_en);

    // R7: the holding register does not change in the cycle it is handed over.
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && !word_is_sync) |-> $stable(hold_word));

    // R3: no trigger and no read while the marker is high.
    assert_quiet_under_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sector_mark |-> (!word_start && !ram_rd_en));

    // R8: the sector number changes only where a new marker begins.
    assert_sector_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sector_idx) |-> $rose(sector_mark));

    // R8: the sector number stays in range.
    assert_sector_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sector_idx) < NUM_SECTORS);

    // R2, R9: a marker begins on a cell boundary.
    assert_mark_on_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sector_mark) |-> cell_tick);

endmodule

bind dsr_read_seq dsr_read_seq_sva #(
    .DATA_W      (DATA_W),
    .NUM_SECTORS (NUM_SECTORS)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .sector_mark  (sector_mark),
    .cell_tick    (cell_tick),
    .word_start   (word_start),
    .word_is_sync (word_is_sync),
    .ram_rd_en    (ram_rd_en),
    .sector_idx   (sector_idx),
    .hold_word    (hold_word)
);

// File: tb/dsr_read_seq_test.sv
module dsr_read_seq_test;

    localparam int DW   = 12;
    localparam int C    = 4;
    localparam int WC   = 5;
    localparam int W    = 6;
    localparam int PRE  = 3;
    localparam int N    = 3;
    localparam int MARK = 6;
    localparam int LEAD = 3;
    localparam logic [DW-1:0] SYNC = 12'hA5C;
    localparam int S    = WC * C;
    localparam int BASE = PRE * C;
    localparam int L    = (PRE + WC * (W + 1)) * C;
    localparam int AW   = $clog2(N * W);
    localparam int SW   = $clog2(N);

    // Probe table: cycle, marker, trigger, read, address, sector.
    localparam int NV = 12;
    localparam int VEC [NV][6] = '{
        '{  0, 1, 0, 0, 0, 0},
        '{  5, 1, 0, 0, 0, 0},
        '{  6, 0, 0, 0, 0, 0},
        '{ 12, 0, 1, 0, 0, 0},
        '{ 29, 0, 0, 1, 0, 0},
        '{ 32, 0, 1, 0, 0, 0},
        '{129, 0, 0, 1, 5, 0},
        '{132, 0, 1, 0, 0, 0},
        '{151, 0, 0, 0, 0, 0},
        '{152, 1, 0, 0, 0, 1},
        '{181, 0, 0, 1, 6, 1},
        '{456, 1, 0, 0, 0, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] ram_rd_data = '0;
    logic          ram_rd_en;
    logic [AW-1:0] ram_addr;
    logic          sector_mark, cell_tick, preamble_active;
    logic          word_start, word_is_sync;
    logic [DW-1:0] word_load;
    logic [SW-1:0] sector_idx;

    int  checks = 0;
    int  fails  = 0;
    int  tcyc   = 0;
    bit  run_chk = 1'b0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    dsr_read_seq #(
        .DATA_W (DW), .CELL_CLKS (C), .WORD_CELLS (WC), .WORDS_PER_SECTOR (W),
        .PREAMBLE_CELLS (PRE), .NUM_SECTORS (N), .MARK_CLKS (MARK),
        .FETCH_LEAD (LEAD), .SYNC_WORD (SYNC)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ram_rd_data (ram_rd_data),
        .ram_rd_en (ram_rd_en), .ram_addr (ram_addr), .sector_mark (sector_mark),
        .cell_tick (cell_tick), .preamble_active (preamble_active),
        .word_start (word_start), .word_is_sync (word_is_sync),
        .word_load (word_load), .sector_idx (sector_idx)
    );

    function automatic logic [DW-1:0] ram_val(int a);
        return DW'(a * 37 + 5);
    endfunction

    // RAM model with one cycle of read latency.
    always @(posedge clk) if (ram_rd_en) ram_rd_data <= ram_val(int'(ram_addr));

    // Cycle count since reset release.
    always @(posedge clk) tcyc <= rst_n ? tcyc + 1 : 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", req, tcyc, act, exp);
        end
    endtask

    // Full-timeline comparison against the sector arithmetic.
    always @(negedge clk) begin
        if (run_chk && rst_n) begin
            int k, o, q, w;
            bit e_start, e_sync, e_rd;
            k = (tcyc / L) % N;
            o = tcyc % L;
            e_sync  = (o >= BASE) && (o < BASE + S);
            e_start = (o >= BASE) && ((o - BASE) % S == 0);
            q = o + LEAD;
            e_rd = (q >= BASE + S) && (q < L) && ((q - BASE) % S == 0);
            chk(sector_mark == (o < MARK), "R2", sector_mark, o < MARK);
            chk(cell_tick == ((tcyc % C) == 0), "R9", cell_tick, (tcyc % C) == 0);
            chk(preamble_active == (o < BASE), "R3", preamble_active, o < BASE);
            chk(word_start == e_start, "R5", word_start, e_start);
            chk(word_is_sync == e_sync, "R4", word_is_sync, e_sync);
            chk(int'(sector_idx) == k, "R8", sector_idx, k);
            chk(ram_rd_en == e_rd, "R6", ram_rd_en, e_rd);
            if (e_rd) begin
                w = (q - BASE) / S - 1;
                chk(int'(ram_addr) == k * W + w, "R6 addr", ram_addr, k * W + w);
            end
            if (e_start && e_sync)
                chk(word_load == SYNC, "R4 sync", word_load, SYNC);
            if (e_start && !e_sync) begin
                w = (o - BASE) / S - 1;
                chk(word_load == ram_val(k * W + w), "R7", word_load, ram_val(k * W + w));
            end
        end
    end

    task automatic check_reset_state(input string tag);
        chk(sector_idx == '0, {tag, " R1 sector"}, sector_idx, 0);
        chk(sector_mark == 1'b1, {tag, " R1 mark"}, sector_mark, 1);
        chk(preamble_active == 1'b1, {tag, " R1 pre"}, preamble_active, 1);
        chk(cell_tick == 1'b1, {tag, " R1 tick"}, cell_tick, 1);
        chk(word_start == 1'b0, {tag, " R1 start"}, word_start, 0);
        chk(ram_rd_en == 1'b0, {tag, " R1 read"}, ram_rd_en, 0);
    endtask

    task automatic wait_t(input int t);
        while (tcyc != t) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("power-up");
        rst_n   = 1'b1;
        run_chk = 1'b1;
        // Probe table: marker edges, sync trigger, first/last reads, wrap.
        for (int i = 0; i < NV; i++) begin
            wait_t(VEC[i][0]);
            chk(sector_mark == VEC[i][1], "R2 probe", sector_mark, VEC[i][1]);
            chk(word_start == VEC[i][2], "R5 probe", word_start, VEC[i][2]);
            chk(ram_rd_en == VEC[i][3], "R6 probe", ram_rd_en, VEC[i][3]);
            if (VEC[i][3] != 0)
                chk(int'(ram_addr) == VEC[i][4], "R6 probe addr", ram_addr, VEC[i][4]);
            chk(int'(sector_idx) == VEC[i][5], "R8 probe", sector_idx, VEC[i][5]);
        end
        // Reset in the middle of a data slot of the third rotation.
        wait_t(1000);
        rst_n   = 1'b0;
        run_chk = 1'b0;
        @(negedge clk);
        check_reset_state("mid-run");
        rst_n   = 1'b1;
        run_chk = 1'b1;
        wait_t(BASE);
        chk(word_start && word_is_sync, "R1 restart trigger", word_start, 1);
        chk(word_load == SYNC, "R4 restart sync", word_load, SYNC);
        wait_t(500);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog t=%0d actual=running expected=done", tcyc);
        finish_run();
    end

endmodule